// File: doc/BRIEF.md
# Debug Serial Port Receive Front-End

This block is the receiving half of a serial debug link. It turns a one-wire data stream into fixed-length parallel frames in the system clock domain. Each frame is delivered with a single-cycle valid strobe.

The line can be clocked in one of two ways, and the choice is strapped after each reset. The block samples the data line on a fixed rising edge of the system clock after reset is released.

- **External-clock mode.** If the strapped level is low, bits arrive on rising edges of an external serial clock. That clock is unrelated to the system clock. Both the serial clock and the data are resynchronised before use.
- **Self-clocked mode.** If the strapped level is high, one bit is taken on every system clock edge.

Start-bit detection stays off for a fixed settling window after reset, so that the strap level and any movement on the line are not read as traffic. When the window ends, the block acts on the current line level:

- If the line is high, the block waits for it to fall before it scans for a start bit.
- If the line is low, it starts scanning at once.

A start bit is a high level. The start bit and the bits that follow it are collected most-significant first.

Top module: `dbg_rx_front`

## Requirements
- R1: Counting rising clock edges from the release of `rst_n` as 1, 2, 3 and so on, the `sdi` level sampled at edge STRAP_CYC (default 8) sets `mode_o`: 0 selects external-clock mode and 1 selects self-clocked mode. The levels at the other edges have no effect on the mode.
- R2: `mode_o` holds its strapped value until the next reset, whatever happens on `sdi` and `sclk`.
- R3: In self-clocked mode, `sdi` is sampled at every rising edge of `clk`. If the start bit is sampled at edge k, `frame_vld_o` is high for exactly the cycle that follows edge k+FRAME_LEN-1.
- R4: In external-clock mode, one bit is taken per rising edge of `sclk`, after a SYNC_STAGES-flop synchronizer. Each `sclk` phase must last at least 2 system clocks. Activity on `sdi` while `sclk` is idle produces no frame.
- R5: No start bit is recognised at or before edge ARM_CYC (default 16). Highs on `sdi` during that window produce no frame. If the line is low at edge ARM_CYC, a start bit can be taken from edge ARM_CYC+1 onward.
- R6: If the data line is high at edge ARM_CYC, the block produces no frame while the line stays high. It begins scanning only after the line has been seen low.
- R7: A frame is FRAME_LEN bits (default 35), including the start bit. `frame_o[FRAME_LEN-1]` is the start bit, which is always 1, and `frame_o[0]` is the last bit received.
- R8: After a frame completes, the block returns to scanning at once. A start bit on the very next bit slot opens a new frame, so back-to-back frames are received.
- R9: `frame_vld_o` is never high for two consecutive cycles. `frame_o` changes only in a cycle where `frame_vld_o` is high, and holds its value between frames.
- R10: Asserting `rst_n` during a frame discards the partial frame: no valid strobe is produced for it. The whole post-reset sequence restarts, including a fresh mode strap.
- R11: While reset is asserted, `frame_o` is 0, `frame_vld_o` is 0 and `mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sdi | input | 1 | Serial data line; also the mode strap |
| sclk | input | 1 | External serial clock, used in external-clock mode |
| frame_o | output | FRAME_LEN | Last received frame, start bit in MSB |
| frame_vld_o | output | 1 | One-cycle strobe when `frame_o` is updated |
| mode_o | output | 1 | Strapped mode: 0 external clock, 1 self-clocked |

## Verification
The assertions watch the following on every cycle:
- the mode stays frozen once the settling window has closed;
- the receiver never leaves its hold state before that window ends;
- a wait-for-low state never leads straight into a frame;
- the bit counter stays in range;
- every valid frame carries a high MSB;
- the valid strobe is a single cycle and the frame register moves only with it.

Some behaviours need the bench's stimulus to show:
- that the strap is taken at exactly one edge;
- that line activity inside the settling window is ignored;
- that a line held high at the end of the window is not read as a start bit;
- that the frame content and strobe timing match in both clocking modes;
- that a reset in mid-frame discards the partial frame and re-straps the mode.

// File: rtl/dbg_rx_pkg.sv
package dbg_rx_pkg;

   // Clocking mode chosen by the reset strap
   typedef enum logic {
      MODE_EXT  = 1'b0,
      MODE_SELF = 1'b1
   } clk_mode_e;

   // Receiver sequencing
   typedef enum logic [1:0] {
      ST_HOLD  = 2'd0,   // settling window after reset
      ST_WAIT  = 2'd1,   // line was high at window end, wait for low
      ST_SCAN  = 2'd2,   // looking for a start bit
      ST_SHIFT = 2'd3    // collecting frame bits
   } rx_state_e;

endpackage

// File: rtl/dbg_rx_strap.sv
module dbg_rx_strap
   import dbg_rx_pkg::*;
#(
   parameter int STRAP_CYC = 8,
   parameter int ARM_CYC   = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sdi_i,
   output clk_mode_e mode_o,
   output logic      open_o,    // high during the cycle that ends the window
   output logic      armed_o    // high once the window has ended
);

   localparam int CW = $clog2(ARM_CYC + 1);

   logic [CW-1:0] cnt_q;
   clk_mode_e     mode_q;
   logic          armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q != CW'(ARM_CYC)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_EXT;
      end else if (cnt_q == CW'(STRAP_CYC - 1)) begin
         mode_q <= clk_mode_e'(sdi_i);
      end
   end

   assign open_o = (cnt_q == CW'(ARM_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (open_o) begin
         armed_q <= 1'b1;
      end
   end

   assign mode_o  = mode_q;
   assign armed_o = armed_q;

   // R2: mode is frozen once the window is over
   p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> $stable(mode_q))
      else $error("mode changed after strap window");

endmodule

// File: rtl/dbg_rx_sync.sv
module dbg_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic sdi_i,
   output logic rise_o,   // one-cycle strobe per external clock rise
   output logic data_o    // data resynchronised alongside the clock
);

   logic [STAGES-1:0] ck_q;
   logic [STAGES-1:0] dt_q;
   logic              ck_prev_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ck_q <= '0;
               dt_q <= '0;
            end else begin
               ck_q <= sclk_i;
               dt_q <= sdi_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ck_q <= '0;
               dt_q <= '0;
            end else begin
               ck_q <= {ck_q[STAGES-2:0], sclk_i};
               dt_q <= {dt_q[STAGES-2:0], sdi_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_prev_q <= 1'b0;
      end else begin
         ck_prev_q <= ck_q[STAGES-1];
      end
   end

   assign rise_o = ck_q[STAGES-1] & ~ck_prev_q;
   assign data_o = dt_q[STAGES-1];

endmodule

// File: rtl/dbg_rx_shift.sv
module dbg_rx_shift
   import dbg_rx_pkg::*;
#(
   parameter int FRAME_LEN = 35
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 open_i,
   input  logic                 armed_i,
   input  logic                 stb_i,
   input  logic                 bit_i,
   input  logic                 lvl_i,
   output logic [FRAME_LEN-1:0] frame_o,
   output logic                 vld_o
);

   localparam int NW = $clog2(FRAME_LEN + 1);
   localparam int SW = FRAME_LEN - 1;

   rx_state_e          st_q;
   logic [NW-1:0]      cnt_q;
   logic [SW-1:0]      sh_q;
   logic [FRAME_LEN-1:0] frame_q;
   logic               vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_HOLD;
         cnt_q   <= '0;
         sh_q    <= '0;
         frame_q <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         unique case (st_q)
            ST_HOLD: begin
               if (open_i) begin
                  st_q <= lvl_i ? ST_WAIT : ST_SCAN;
               end
            end
            ST_WAIT: begin
               if (!lvl_i) begin
                  st_q <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (stb_i && bit_i) begin
                  sh_q  <= SW'(1);
                  cnt_q <= NW'(1);
                  st_q  <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (stb_i) begin
                  if (cnt_q == NW'(FRAME_LEN - 1)) begin
                     frame_q <= {sh_q, bit_i};
                     vld_q   <= 1'b1;
                     cnt_q   <= '0;
                     st_q    <= ST_SCAN;
                  end else begin
                     sh_q  <= {sh_q[SW-2:0], bit_i};
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: st_q <= ST_HOLD;
         endcase
      end
   end

   assign frame_o = frame_q;
   assign vld_o   = vld_q;

   // R5: no activity leaves the hold state before the window closes
   p_hold_until_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_HOLD) |-> armed_i)
      else $error("receiver left hold before window end");

   // R6: waiting for a low line never goes straight into a frame
   p_wait_no_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT) |=> (st_q != ST_SHIFT))
      else $error("frame started while line was still high");

   // R7: every delivered frame carries the start bit in its MSB
   p_start_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> frame_q[FRAME_LEN-1])
      else $error("frame MSB not set");

   // R8: bit counter stays inside the frame while shifting
   p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SHIFT) |-> (cnt_q != '0 && cnt_q < NW'(FRAME_LEN)))
      else $error("bit counter out of range");

   // R9: single-cycle strobe
   p_vld_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q)
      else $error("valid strobe longer than one cycle");

   // R9: frame register only moves together with the strobe
   p_frame_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_q) |-> vld_q)
      else $error("frame changed without strobe");

endmodule

// File: rtl/dbg_rx_front.sv
module dbg_rx_front
   import dbg_rx_pkg::*;
#(
   parameter int FRAME_LEN   = 35,
   parameter int STRAP_CYC   = 8,
   parameter int ARM_CYC     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sdi,
   input  logic                 sclk,
   output logic [FRAME_LEN-1:0] frame_o,
   output logic                 frame_vld_o,
   output logic                 mode_o
);

   generate
      if (FRAME_LEN < 3) begin : g_bad_len
         $error("FRAME_LEN must be at least 3");
      end
      if (STRAP_CYC < 1) begin : g_bad_strap
         $error("STRAP_CYC must be at least 1");
      end
      if (ARM_CYC <= STRAP_CYC) begin : g_bad_arm
         $error("ARM_CYC must exceed STRAP_CYC");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   clk_mode_e mode;
   logic      open_w, armed_w;
   logic      rise_w, sdat_w;
   logic      is_self, stb_w, bit_w;

   dbg_rx_strap #(
      .STRAP_CYC (STRAP_CYC),
      .ARM_CYC   (ARM_CYC)
   ) u_strap (
      .clk     (clk),
      .rst_n   (rst_n),
      .sdi_i   (sdi),
      .mode_o  (mode),
      .open_o  (open_w),
      .armed_o (armed_w)
   );

   dbg_rx_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (sclk),
      .sdi_i  (sdi),
      .rise_o (rise_w),
      .data_o (sdat_w)
   );

   assign is_self = (mode == MODE_SELF);
   assign stb_w   = is_self | rise_w;
   assign bit_w   = is_self ? sdi : sdat_w;

   dbg_rx_shift #(
      .FRAME_LEN (FRAME_LEN)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .open_i  (open_w),
      .armed_i (armed_w),
      .stb_i   (stb_w),
      .bit_i   (bit_w),
      .lvl_i   (bit_w),
      .frame_o (frame_o),
      .vld_o   (frame_vld_o)
   );

   assign mode_o = mode;

endmodule

// File: tb/dbg_rx_front_tb.sv
module dbg_rx_front_tb;

   localparam int FL = 35;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sdi = 1'b0;
   logic          sclk = 1'b0;
   logic [FL-1:0] frame_o;
   logic          frame_vld_o;
   logic          mode_o;

   int total = 0;
   int bad   = 0;
   int vld_cnt = 0;
   logic [FL-1:0] last_fr = '0;

   always #4 clk = ~clk;

   dbg_rx_front u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sdi         (sdi),
      .sclk        (sclk),
      .frame_o     (frame_o),
      .frame_vld_o (frame_vld_o),
      .mode_o      (mode_o)
   );

   // strobe monitor
   always @(negedge clk) begin
      if (rst_n && frame_vld_o) begin
         vld_cnt++;
         last_fr = frame_o;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [FL-1:0] mk_frame();
      logic [FL-1:0] f;
      f = FL'({$urandom, $urandom});
      f[FL-1] = 1'b1;
      return f;
   endfunction

   // edges 1..7 carry the opposite level, edge 8 the strap,
   // 9..15 optional noise, 16 the given end-of-window level
   task automatic reset_seq(input bit strap, input bit noise, input bit high16);
      rst_n = 1'b0;
      sdi   = 1'b0;
      sclk  = 1'b0;
      tick(3);
      rst_n = 1'b1;
      for (int e = 1; e <= 16; e++) begin
         if (e < 8)       sdi = ~strap;
         else if (e == 8) sdi = strap;
         else if (e < 16) sdi = noise;
         else             sdi = high16;
         tick();
      end
   endtask

   task automatic send_self(input logic [FL-1:0] f, input bool_chk);
      for (int i = FL - 1; i >= 0; i--) begin
         sdi = f[i];
         tick();
      end
      sdi = 1'b0;
      if (bool_chk) begin
         chk(frame_vld_o == 1'b1, "R3 strobe timing", 64'(frame_vld_o), 64'd1);
         chk(frame_o == f, "R7 frame content", 64'(frame_o), 64'(f));
      end
   endtask

   task automatic send_ext(input logic [FL-1:0] f, input int nbits);
      for (int i = FL - 1; i >= FL - nbits; i--) begin
         sdi = f[i];
         tick(2);
         sclk = 1'b1;
         tick(3);
         sclk = 1'b0;
         tick(1);
      end
      sdi = 1'b0;
   endtask

   initial begin
      logic [FL-1:0] f, g;
      int base;
      void'($urandom(32'h5EED_1234));

      // R11: reset state
      tick(2);
      chk(frame_o == '0, "R11 frame in reset", 64'(frame_o), 64'd0);
      chk(frame_vld_o == 1'b0, "R11 valid in reset", 64'(frame_vld_o), 64'd0);
      chk(mode_o == 1'b0, "R11 mode in reset", 64'(mode_o), 64'd0);

      // self-clocked: strap high only at edge 8 (R1), first start at edge 17 (R5)
      reset_seq(1'b1, 1'b0, 1'b0);
      chk(mode_o == 1'b1, "R1 strap self", 64'(mode_o), 64'd1);
      chk(vld_cnt == 0, "R5 no frame in window", 64'(vld_cnt), 64'd0);
      f = mk_frame();
      send_self(f, 1'b1);
      tick();
      chk(frame_vld_o == 1'b0, "R9 strobe one cycle", 64'(frame_vld_o), 64'd0);
      chk(frame_o == f, "R9 frame holds", 64'(frame_o), 64'(f));
      for (int k = 0; k < 3; k++) begin
         tick(1 + ($urandom % 5));
         f = mk_frame();
         send_self(f, 1'b1);
      end
      // R8: back-to-back
      f = mk_frame();
      g = mk_frame();
      send_self(f, 1'b1);
      send_self(g, 1'b1);
      chk(mode_o == 1'b1, "R2 mode held", 64'(mode_o), 64'd1);

      // R5: noise inside the window ignored
      reset_seq(1'b1, 1'b1, 1'b0);
      base = vld_cnt;
      tick(60);
      chk(vld_cnt == base, "R5 window noise ignored", 64'(vld_cnt), 64'(base));
      f = mk_frame();
      send_self(f, 1'b1);

      // R6: line high at window end
      reset_seq(1'b1, 1'b0, 1'b1);
      base = vld_cnt;
      sdi = 1'b1;
      tick(60);
      chk(vld_cnt == base, "R6 held-high line no frame", 64'(vld_cnt), 64'(base));
      sdi = 1'b0;
      tick();
      f = mk_frame();
      send_self(f, 1'b1);

      // external clock: strap low only at edge 8
      reset_seq(1'b0, 1'b0, 1'b0);
      chk(mode_o == 1'b0, "R1 strap ext", 64'(mode_o), 64'd0);
      tick(3);
      for (int k = 0; k < 3; k++) begin
         base = vld_cnt;
         f = mk_frame();
         send_ext(f, FL);
         tick(4);
         chk(vld_cnt == base + 1, "R4 one frame per ext burst", 64'(vld_cnt), 64'(base + 1));
         chk(last_fr == f, "R4 ext frame content", 64'(last_fr), 64'(f));
      end
      // R4: data movement without serial clock
      base = vld_cnt;
      for (int k = 0; k < 40; k++) begin
         sdi = $urandom % 2;
         tick();
      end
      sdi = 1'b0;
      tick(4);
      chk(vld_cnt == base, "R4 no clock no frame", 64'(vld_cnt), 64'(base));
      chk(mode_o == 1'b0, "R2 mode held ext", 64'(mode_o), 64'd0);

      // R10: partial ext frame, reset, restrap as self-clocked
      f = mk_frame();
      send_ext(f, 10);
      rst_n = 1'b0;
      tick();
      chk(frame_vld_o == 1'b0, "R10 valid cleared", 64'(frame_vld_o), 64'd0);
      chk(frame_o == '0, "R10 frame cleared", 64'(frame_o), 64'd0);
      base = vld_cnt;
      reset_seq(1'b1, 1'b0, 1'b0);
      chk(mode_o == 1'b1, "R10 mode re-strapped", 64'(mode_o), 64'd1);
      tick(60);
      chk(vld_cnt == base, "R10 partial discarded", 64'(vld_cnt), 64'(base));
      f = mk_frame();
      send_self(f, 1'b1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule